// File: doc/BRIEF.md
# Exclusion-Aware Random Colour Tag Generator

This block hands out a fresh 4-bit colour tag each time an allocator asks for one. It draws the value at random from the sixteen possible tags, but never returns a value that is excluded. A value is excluded if it is reserved, if it is set in a caller-supplied static mask, or if it matches any of three dynamic tags. The dynamic tags are the tag the allocation held before and the tags of the allocations directly below and above it in memory. Because of these exclusions, a stale pointer or a linear overflow into a neighbour can never keep a matching colour.

Randomness comes from a 16-bit maximal-length LFSR that steps on every clock and can be reseeded at any time. The selection has no retry loop. The block counts the permitted values, scales a random word into an index below that count, and returns the permitted value at that rank. Every request is answered exactly two cycles later, and a new request may be issued on every cycle. If a request leaves no permitted value, the block returns a fixed fallback tag and flags the answer as an error.

Top module: `tag_gen`

## Requirements
- R1: A request sampled high on a rising edge produces `tag_valid` high for exactly one cycle, two rising edges later. Back-to-back requests produce back-to-back answers in the same order.
- R2: The excluded set is the OR of the reserved mask, `excl_static` (bit i excludes tag i), and the one-hot decodes of `prev_tag`, `left_tag` and `right_tag`. Whenever at least one value is permitted, the returned tag lies outside this set.
- R3: The reserved mask (parameter `RESERVED`, default bit 0, so tag 0) is excluded even when `excl_static` is all zeros.
- R4: When exactly one value is permitted, that value is returned.
- R5: When every value is excluded, `tag_err` is 1 with the answer and the tag is the lowest value not in `RESERVED` (tag 1 by default). Otherwise `tag_err` is 0.
- R6: The index is (random word × permitted count) >> 16, so every permitted value can be returned. Over many draws from four permitted values, each value appears.
- R7: The random source is a nonzero 16-bit LFSR that changes state on every cycle without a load. `seed_load` loads `seed_val`, and a zero seed is replaced by 1. The same seed followed by the same request timing gives the same tag sequence.
- R8: In reset, and after it, `tag_valid`, `tag_err` and `tag_out` are all 0 until the first answer.
- R9: In any cycle where `tag_valid` is 0, `tag_out` is 0 and `tag_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_val` into the LFSR |
| seed_val | input | 16 | LFSR seed (0 becomes 1) |
| req | input | 1 | Request one tag |
| excl_static | input | 16 | Static exclusion mask, bit i excludes tag i |
| prev_tag | input | 4 | Tag previously held by the allocation |
| left_tag | input | 4 | Tag of the lower neighbour |
| right_tag | input | 4 | Tag of the upper neighbour |
| tag_out | output | 4 | Chosen tag |
| tag_valid | output | 1 | One-cycle strobe marking `tag_out` |
| tag_err | output | 1 | No permitted value existed for this answer |

## Verification
The bound checker keeps its own delayed copy of each request and its exclusion set. On every cycle it checks the fixed two-cycle latency, that answers never land in the excluded or reserved sets, the error flag and its fallback value, the quiet outputs between answers, and that the LFSR keeps moving and never reaches zero. Some properties can only be seen across a whole scenario: that every permitted value is actually reachable, that a single permitted value is chosen exactly, and that reseeding reproduces a sequence. The bench's scoreboard and its collected tag histories show these.

// File: rtl/tagrng_pkg.sv
`timescale 1ns/1ps
package tagrng_pkg;

    localparam int TAG_W    = 4;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int CNT_W    = TAG_W + 1;
    localparam int RND_W    = 16;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [NUM_TAGS-1:0] tmask_t;
    typedef logic [CNT_W-1:0]    tcnt_t;
    typedef logic [RND_W-1:0]    rnd_t;

    // Stage between mask merge and pick
    typedef struct packed {
        logic   vld;
        logic   none;
        tmask_t allow;
        tcnt_t  cnt;
    } merge_t;

    // Registered answer
    typedef struct packed {
        logic vld;
        logic err;
        tag_t tag;
    } answer_t;

    function automatic tmask_t tag_onehot(tag_t t);
        tmask_t m;
        m = '0;
        m[t] = 1'b1;
        return m;
    endfunction

    function automatic tcnt_t tag_count(tmask_t m);
        tcnt_t c;
        c = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (m[i]) c = c + tcnt_t'(1);
        end
        return c;
    endfunction

    // Position of the n-th set bit (n counted from 0)
    function automatic tag_t tag_nth(tmask_t m, tcnt_t n);
        tcnt_t seen;
        tag_t  r;
        seen = '0;
        r    = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (m[i]) begin
                if (seen == n) r = tag_t'(i);
                seen = seen + tcnt_t'(1);
            end
        end
        return r;
    endfunction

    // Lowest value whose bit is clear in m
    function automatic tag_t tag_lowest_clear(tmask_t m);
        tag_t r;
        logic hit;
        r   = '0;
        hit = 1'b0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (!m[i] && !hit) begin
                r   = tag_t'(i);
                hit = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tagrng_lfsr.sv
`timescale 1ns/1ps
module tagrng_lfsr
    import tagrng_pkg::*;
#(
    parameter rnd_t TAPS       = 16'hB400,
    parameter rnd_t RESET_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  rnd_t seed,
    output rnd_t state
);
    rnd_t state_q;
    rnd_t step;

    // Right-shifting Galois form
    always_comb begin
        step = {1'b0, state_q[RND_W-1:1]};
        if (state_q[0]) step = step ^ TAPS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_SEED;
        end else if (load) begin
            state_q <= (seed == '0) ? rnd_t'(1) : seed;
        end else begin
            state_q <= step;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/tagrng_merge.sv
`timescale 1ns/1ps
module tagrng_merge
    import tagrng_pkg::*;
#(
    parameter tmask_t RESERVED = 16'h0001
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  tmask_t excl_static,
    input  tag_t   prev_tag,
    input  tag_t   left_tag,
    input  tag_t   right_tag,
    output merge_t stage
);
    tmask_t blocked;
    merge_t nxt;
    merge_t stage_q;

    always_comb begin
        blocked   = RESERVED | excl_static
                  | tag_onehot(prev_tag)
                  | tag_onehot(left_tag)
                  | tag_onehot(right_tag);
        nxt.vld   = req;
        nxt.allow = req ? ~blocked : '0;
        nxt.cnt   = tag_count(nxt.allow);
        nxt.none  = req && (blocked == '1);
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= nxt;
    end

    assign stage = stage_q;
endmodule

// File: rtl/tagrng_pick.sv
`timescale 1ns/1ps
module tagrng_pick
    import tagrng_pkg::*;
#(
    parameter tmask_t RESERVED = 16'h0001
) (
    input  logic    clk,
    input  logic    rst,
    input  merge_t  stage,
    input  rnd_t    rnd,
    output answer_t ans
);
    localparam int PROD_W = RND_W + CNT_W;
    localparam tag_t FALLBACK = tag_lowest_clear(RESERVED);

    logic [PROD_W-1:0] prod;
    tcnt_t             rank;
    answer_t           nxt;
    answer_t           ans_q;

    always_comb begin
        prod = {{CNT_W{1'b0}}, rnd} * {{RND_W{1'b0}}, stage.cnt};
        rank = prod[RND_W +: CNT_W];
        nxt  = '0;
        if (stage.vld) begin
            nxt.vld = 1'b1;
            if (stage.none) begin
                nxt.err = 1'b1;
                nxt.tag = FALLBACK;
            end else begin
                nxt.tag = tag_nth(stage.allow, rank);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ans_q <= '0;
        else     ans_q <= nxt;
    end

    assign ans = ans_q;
endmodule

// File: rtl/tag_gen.sv
`timescale 1ns/1ps
module tag_gen
    import tagrng_pkg::*;
#(
    parameter logic [15:0] RESERVED   = 16'h0001,
    parameter logic [15:0] LFSR_TAPS  = 16'hB400,
    parameter logic [15:0] RESET_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        seed_load,
    input  logic [15:0] seed_val,
    input  logic        req,
    input  logic [15:0] excl_static,
    input  logic [3:0]  prev_tag,
    input  logic [3:0]  left_tag,
    input  logic [3:0]  right_tag,
    output logic [3:0]  tag_out,
    output logic        tag_valid,
    output logic        tag_err
);
    rnd_t    rnd_q;
    merge_t  merged;
    answer_t ans;

    tagrng_lfsr #(.TAPS(LFSR_TAPS), .RESET_SEED(RESET_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (seed_load),
        .seed  (seed_val),
        .state (rnd_q)
    );

    tagrng_merge #(.RESERVED(RESERVED)) u_merge (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .excl_static (excl_static),
        .prev_tag    (prev_tag),
        .left_tag    (left_tag),
        .right_tag   (right_tag),
        .stage       (merged)
    );

    tagrng_pick #(.RESERVED(RESERVED)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .stage (merged),
        .rnd   (rnd_q),
        .ans   (ans)
    );

    assign tag_out   = ans.tag;
    assign tag_valid = ans.vld;
    assign tag_err   = ans.err;
endmodule

// File: rtl/tag_gen_chk.sv
`timescale 1ns/1ps
module tag_gen_chk #(
    parameter logic [15:0] RESERVED = 16'h0001
) (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        seed_load,
    input logic [15:0] excl_static,
    input logic [3:0]  prev_tag,
    input logic [3:0]  left_tag,
    input logic [3:0]  right_tag,
    input logic [3:0]  tag_out,
    input logic        tag_valid,
    input logic        tag_err,
    input logic [15:0] lfsr_state
);
    logic [1:0]  req_pipe;
    logic [15:0] ex_d1, ex_d2, ex_now;
    logic [3:0]  fallback;

    always_comb begin
        ex_now = RESERVED | excl_static | (16'd1 << prev_tag)
               | (16'd1 << left_tag) | (16'd1 << right_tag);
        fallback = 4'd0;
        for (int i = 15; i >= 0; i--) begin
            if (!RESERVED[i]) fallback = 4'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_pipe <= '0;
            ex_d1    <= '0;
            ex_d2    <= '0;
        end else begin
            req_pipe <= {req_pipe[0], req};
            ex_d1    <= ex_now;
            ex_d2    <= ex_d1;
        end
    end

    // R1
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        tag_valid == req_pipe[1]);

    // R2
    not_excluded_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && !tag_err) |-> !ex_d2[tag_out]);

    // R3
    never_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> !RESERVED[tag_out]);

    // R5
    err_flag_chk: assert property (@(posedge clk) disable iff (rst)
        tag_valid |-> (tag_err == (ex_d2 == 16'hFFFF)));

    // R5
    fallback_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_valid && tag_err) |-> (tag_out == fallback));

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tag_valid |-> (tag_out == 4'd0 && !tag_err));

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'd0);

    // R7
    lfsr_steps_chk: assert property (@(posedge clk) disable iff (rst)
        !seed_load |=> (lfsr_state != $past(lfsr_state)));
endmodule

bind tag_gen tag_gen_chk #(.RESERVED(RESERVED)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .seed_load   (seed_load),
    .excl_static (excl_static),
    .prev_tag    (prev_tag),
    .left_tag    (left_tag),
    .right_tag   (right_tag),
    .tag_out     (tag_out),
    .tag_valid   (tag_valid),
    .tag_err     (tag_err),
    .lfsr_state  (rnd_q)
);

// File: tb/tag_gen_test.sv
`timescale 1ns/1ps
module tag_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic        req = 1'b0;
    logic [15:0] excl_static = '0;
    logic [3:0]  prev_tag = '0, left_tag = '0, right_tag = '0;
    logic [3:0]  tag_out;
    logic        tag_valid, tag_err;

    always #2 clk = ~clk;   // 250 MHz

    tag_gen uut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_val(seed_val),
        .req(req), .excl_static(excl_static), .prev_tag(prev_tag),
        .left_tag(left_tag), .right_tag(right_tag),
        .tag_out(tag_out), .tag_valid(tag_valid), .tag_err(tag_err)
    );

    typedef struct {
        int          cyc;
        logic [15:0] excl;
        logic        err;
        logic        exact;
        logic [3:0]  etag;
    } exp_t;

    exp_t       sb[$];
    logic [3:0] got[$];
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string rq, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // Driver: independent model of the exclusion rule
    task automatic issue(logic [15:0] st, logic [3:0] p, logic [3:0] l, logic [3:0] r);
        exp_t e;
        @(negedge clk);
        req = 1'b1; excl_static = st; prev_tag = p; left_tag = l; right_tag = r;
        e.cyc   = cyc;
        e.excl  = st | 16'h0001 | (16'd1 << p) | (16'd1 << l) | (16'd1 << r);
        e.err   = (e.excl == 16'hFFFF);
        e.exact = e.err || ($countones(~e.excl) == 1);
        e.etag  = 4'd1;
        if (!e.err)
            for (int i = 0; i < 16; i++) if (!e.excl[i]) e.etag = 4'(i);
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 1'b0;
        end
    endtask

    task automatic drain;
        idle(1);
        while (sb.size() != 0) @(negedge clk);
        idle(2);
    endtask

    task automatic reseed(logic [15:0] s);
        @(negedge clk);
        req = 1'b0; seed_load = 1'b1; seed_val = s;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            if (tag_valid) begin
                if (sb.size() == 0) begin
                    check(0, "R1 unexpected answer", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.cyc + 2, "R1 latency", cyc - e.cyc, 2);
                    check(tag_err == e.err, "R5 error flag", tag_err, e.err);
                    if (e.exact)
                        check(tag_out == e.etag, e.err ? "R5 fallback" : "R4 single value",
                              tag_out, e.etag);
                    else
                        check(!e.excl[tag_out] && tag_out != 0, "R2/R3 excluded tag",
                              tag_out, -1);
                    got.push_back(tag_out);
                end
            end else begin
                if (tag_out != 0 || tag_err) check(0, "R9 idle outputs", tag_out, 0);
                if (sb.size() != 0 && cyc > sb[0].cyc + 2)
                    check(0, "R1 missing answer", cyc - sb[0].cyc, 2);
            end
        end
    end

    initial begin
        logic [3:0] seq_a[$], seq_b[$];
        bit         seen[16];
        repeat (3) @(negedge clk);
        // R8: outputs quiet during reset
        check(tag_valid == 0 && tag_err == 0 && tag_out == 0, "R8 reset state",
              {tag_valid, tag_err, tag_out}, 0);
        @(negedge clk); rst = 1'b0;
        idle(2);
        check(tag_valid == 0 && tag_err == 0 && tag_out == 0, "R8 after reset",
              {tag_valid, tag_err, tag_out}, 0);

        // R2: mixed patterns, back-to-back and spaced
        for (int i = 0; i < 40; i++) begin
            issue(16'((i * 16'h2B17) ^ (i << 3)) & 16'h7EF6, 4'(i), 4'(i * 5), 4'(i * 11 + 3));
            if (i % 4 == 3) idle(i % 3);
        end
        drain();

        // R3: empty static mask still avoids tag 0
        for (int i = 0; i < 12; i++) issue(16'h0000, 4'd5, 4'd6, 4'd7);
        drain();

        // R4: a single permitted value
        issue(~16'h0200, 4'd1, 4'd2, 4'd3);
        issue(16'hFFFF & ~16'h8000, 4'd0, 4'd0, 4'd0);
        issue(16'h0FFE, 4'd12, 4'd13, 4'd14);   // only 15 left
        drain();

        // R5: everything excluded, including through dynamic tags
        issue(16'hFFFF, 4'd3, 4'd3, 4'd3);
        issue(16'hFFF0, 4'd1, 4'd2, 4'd3);      // reserved covers 0
        issue(16'hFFF0, 4'd1, 4'd2, 4'd2);      // tag 3 still free
        drain();

        // R6: four permitted values, each must show up
        reseed(16'h1234);
        got.delete();
        for (int i = 0; i < 80; i++) begin
            issue(~16'h4824, 4'd0, 4'd0, 4'd0);  // allows 2,5,11,14
            idle(i % 3);
        end
        drain();
        foreach (seen[i]) seen[i] = 0;
        foreach (got[i]) seen[got[i]] = 1;
        check(seen[2] && seen[5] && seen[11] && seen[14], "R6 coverage of permitted values",
              {seen[2], seen[5], seen[11], seen[14]}, 4'hF);

        // R7: reseed reproduces a sequence; zero seed behaves as 1
        for (int pass = 0; pass < 2; pass++) begin
            reseed(16'hACE1);
            got.delete();
            idle(3);
            for (int i = 0; i < 12; i++) issue(16'h0000, 4'd0, 4'd0, 4'd0);
            drain();
            if (pass == 0) seq_a = got; else seq_b = got;
        end
        check(seq_a == seq_b, "R7 repeat with same seed", seq_b.size(), seq_a.size());
        for (int pass = 0; pass < 2; pass++) begin
            reseed(pass == 0 ? 16'h0001 : 16'h0000);
            got.delete();
            for (int i = 0; i < 12; i++) issue(16'h0000, 4'd0, 4'd0, 4'd0);
            drain();
            if (pass == 0) seq_a = got; else seq_b = got;
        end
        check(seq_a == seq_b, "R7 zero seed equals seed 1", seq_b.size(), seq_a.size());

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule